// File: doc/BRIEF.md
# BCD Calendar Update Engine

This block keeps a wall-clock calendar made of seconds, minutes, hours, weekday, day of month, month and a two-digit year. It advances by one second on each strobe of a 1 Hz enable, but only while the oscillator control field holds its run code. The time is kept internally in binary. A separate bank of visible registers presents it, either as packed BCD or as plain binary and either in 24-hour form or in 12-hour form with a PM flag.

Each accepted second starts an update window. While the window is open, an update-in-progress flag is high and the visible registers keep their old values. When the window closes, the visible registers take the new time. At the same moment the alarm bytes are compared against them and one-cycle flag pulses are raised for update-ended, alarm and interrupt request.

A load request decodes a set of register-format values into the internal time, using the current format controls. It also abandons any update window that is still running.

Top module: `rtc_cal_engine`

## Requirements
- R1: A strobe on `tick_1hz` is accepted only when `osc_sel` equals 3'b010. With any other code the time does not advance, `uip_o` stays low and no flag pulse is produced.
- R2: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. At midnight the weekday wraps from 7 to 1, the month wraps from 12 to 1 and increments the year, and year 99 wraps to 00.
- R3: Months 4, 6, 9 and 11 have 30 days. February has 29 days in a leap year and 28 otherwise. The full year is BASE_CENTURY*100 plus the two-digit year, and it is a leap year when divisible by 4 and either not divisible by 100 or divisible by 400. All other months have 31 days.
- R4: With `fmt_binary` low, each register holds BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With `fmt_binary` high, each register holds the plain binary value. Load values are decoded in the same form.
- R5: With `fmt_24h` low, the hour register holds hour modulo 12 and sets bit 7 for hours 12 to 23. On a load in this mode, bit 7 adds 12 to the decoded hour.
- R6: An accepted strobe raises `uip_o` for UIP_CYCLES clock cycles. The visible registers keep their old values during that time and take the new time on the same edge at which `uip_o` falls.
- R7: While `set_hold` is high, `uip_o` stays low and the visible registers are not refreshed. The internal time still advances, and `uf_pulse_o` is still raised at the end of the window.
- R8: When `alarm_en` is high at the end of a window, `af_pulse_o` pulses if the seconds, minutes and hours alarm bytes each either equal the new register value or have bits 7:6 both set (a wildcard).
- R9: Every completed window pulses `uf_pulse_o` for one cycle. `irq_pulse_o` pulses with it when `upd_irq_en` is high or when an alarm fires.
- R10: On a load request the visible registers show the loaded time one cycle after the request cycle. A window that is still open is abandoned: `uip_o` drops and no flag pulse follows.
- R11: After reset the registers read 00:00:00, weekday 01, day 01, month 01, year 00, and `uip_o` and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| osc_sel | input | 3 | Oscillator control code; 3'b010 runs the clock |
| set_hold | input | 1 | Freezes the visible registers and the progress flag |
| fmt_binary | input | 1 | 1 selects binary registers, 0 selects BCD |
| fmt_24h | input | 1 | 1 selects 24-hour form, 0 selects 12-hour form with PM bit |
| alarm_en | input | 1 | Enables the alarm match |
| upd_irq_en | input | 1 | Enables an interrupt request on every update end |
| alarm_sec | input | 8 | Seconds alarm byte |
| alarm_min | input | 8 | Minutes alarm byte |
| alarm_hour | input | 8 | Hours alarm byte |
| load_req | input | 1 | Loads the load_* values into the calendar |
| load_sec | input | 8 | Seconds value to load |
| load_min | input | 8 | Minutes value to load |
| load_hour | input | 8 | Hours value to load |
| load_wday | input | 8 | Weekday value to load (1..7) |
| load_mday | input | 8 | Day-of-month value to load |
| load_mon | input | 8 | Month value to load (1..12) |
| load_year | input | 8 | Two-digit year value to load |
| sec_o | output | 8 | Visible seconds register |
| min_o | output | 8 | Visible minutes register |
| hour_o | output | 8 | Visible hours register |
| wday_o | output | 8 | Visible weekday register |
| mday_o | output | 8 | Visible day-of-month register |
| mon_o | output | 8 | Visible month register |
| year_o | output | 8 | Visible year register |
| uip_o | output | 1 | Update in progress |
| uf_pulse_o | output | 1 | Update-ended pulse |
| af_pulse_o | output | 1 | Alarm pulse |
| irq_pulse_o | output | 1 | Interrupt request pulse |

## Verification
The range check on the internal time assumes that every load carries a legal calendar date in the selected format. The bench only loads such dates. The visible-register property relies on `set_hold` not falling while a window is open, so the bench changes `set_hold` only between windows. The bench also spaces its strobes more than UIP_CYCLES cycles apart, so that no strobe lands inside a running window.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_regs_t;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_BUSY
    } seq_state_e;

    localparam cal_time_t CAL_EPOCH = '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                                        hour: 5'd0, min: 6'd0, sec: 6'd0};

    localparam cal_regs_t CAL_REGS_RESET = '{year: 8'h00, mon: 8'h01, mday: 8'h01, wday: 8'h01,
                                             hour: 8'h00, min: 8'h00, sec: 8'h00};

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 7'd10);
        ones = 4'(v % 7'd10);
        return {tens, ones};
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return (7'(b[7:4]) * 7'd10) + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] field_enc(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : bin_to_bcd(v);
    endfunction

    function automatic logic [6:0] field_dec(input logic [7:0] b, input logic bin);
        return bin ? b[6:0] : bcd_to_bin(b);
    endfunction

    function automatic logic is_leap(input logic [6:0] yy, input int century);
        return (yy[1:0] == 2'b00) && ((yy != 7'd0) || ((century % 4) == 0));
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
        case (mon)
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            4'd2:                    return leap ? 5'd29 : 5'd28;
            default:                 return 5'd31;
        endcase
    endfunction

    function automatic cal_time_t next_second(input cal_time_t t, input logic leap);
        cal_time_t n;
        n = t;
        if (t.sec == 6'd59) begin
            n.sec = 6'd0;
            if (t.min == 6'd59) begin
                n.min = 6'd0;
                if (t.hour == 5'd23) begin
                    n.hour = 5'd0;
                    n.wday = (t.wday == 3'd7) ? 3'd1 : t.wday + 3'd1;
                    if (t.mday >= month_len(t.mon, leap)) begin
                        n.mday = 5'd1;
                        if (t.mon == 4'd12) begin
                            n.mon  = 4'd1;
                            n.year = (t.year == 7'd99) ? 7'd0 : t.year + 7'd1;
                        end else begin
                            n.mon = t.mon + 4'd1;
                        end
                    end else begin
                        n.mday = t.mday + 5'd1;
                    end
                end else begin
                    n.hour = t.hour + 5'd1;
                end
            end else begin
                n.min = t.min + 6'd1;
            end
        end else begin
            n.sec = t.sec + 6'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_cal_codec.sv
module rtc_cal_codec
    import rtc_cal_pkg::*;
(
    input  logic      fmt_binary,
    input  logic      fmt_24h,
    input  cal_time_t time_i,
    input  cal_regs_t load_regs_i,
    output cal_regs_t regs_o,
    output cal_time_t time_o
);

    logic       pm;
    logic [4:0] hr12;
    logic [6:0] hr_raw;

    assign pm   = (time_i.hour >= 5'd12);
    assign hr12 = pm ? (time_i.hour - 5'd12) : time_i.hour;

    always_comb begin
        regs_o.sec  = field_enc({1'b0, time_i.sec}, fmt_binary);
        regs_o.min  = field_enc({1'b0, time_i.min}, fmt_binary);
        regs_o.wday = field_enc({4'd0, time_i.wday}, fmt_binary);
        regs_o.mday = field_enc({2'd0, time_i.mday}, fmt_binary);
        regs_o.mon  = field_enc({3'd0, time_i.mon}, fmt_binary);
        regs_o.year = field_enc(time_i.year, fmt_binary);
        if (fmt_24h) begin
            regs_o.hour = field_enc({2'd0, time_i.hour}, fmt_binary);
        end else begin
            regs_o.hour = field_enc({2'd0, hr12}, fmt_binary) | {pm, 7'd0};
        end
    end

    always_comb begin
        if (fmt_24h) begin
            hr_raw = field_dec(load_regs_i.hour, fmt_binary);
        end else begin
            hr_raw = field_dec({1'b0, load_regs_i.hour[6:0]}, fmt_binary);
        end
        time_o.sec  = 6'(field_dec(load_regs_i.sec, fmt_binary));
        time_o.min  = 6'(field_dec(load_regs_i.min, fmt_binary));
        time_o.wday = 3'(field_dec(load_regs_i.wday, fmt_binary));
        time_o.mday = 5'(field_dec(load_regs_i.mday, fmt_binary));
        time_o.mon  = 4'(field_dec(load_regs_i.mon, fmt_binary));
        time_o.year = field_dec(load_regs_i.year, fmt_binary);
        time_o.hour = 5'(hr_raw) + ((!fmt_24h && load_regs_i.hour[7]) ? 5'd12 : 5'd0);
    end

endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
#(
    parameter int BASE_CENTURY = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    input  cal_time_t load_time_i,
    input  logic      adv_i,
    output cal_time_t time_o
);

    cal_time_t time_q;
    logic      leap;

    assign leap   = is_leap(time_q.year, BASE_CENTURY);
    assign time_o = time_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= CAL_EPOCH;
        end else if (load_i) begin
            time_q <= load_time_i;
        end else if (adv_i) begin
            time_q <= next_second(time_q, leap);
        end
    end

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
    import rtc_cal_pkg::*;
#(
    parameter int UIP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic cancel_i,
    input  logic set_hold_i,
    output logic busy_o,
    output logic uip_o,
    output logic finish_o
);

    localparam int CW = (UIP_CYCLES > 1) ? $clog2(UIP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(UIP_CYCLES - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          uip_q;

    assign busy_o   = (state_q == SEQ_BUSY);
    assign uip_o    = uip_q;
    assign finish_o = busy_o && (cnt_q == LAST) && !cancel_i;

    always_ff @(posedge clk) begin
        if (rst || cancel_i) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            uip_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SEQ_BUSY;
                        cnt_q   <= '0;
                        uip_q   <= !set_hold_i;
                    end
                end
                SEQ_BUSY: begin
                    if (finish_o) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                        uip_q   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                        uip_q <= uip_q && !set_hold_i;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  cal_regs_t  regs_i,
    input  logic [7:0] alarm_sec,
    input  logic [7:0] alarm_min,
    input  logic [7:0] alarm_hour,
    output logic       hit_o
);

    localparam int NFIELD = 3;

    logic [7:0]        cur [NFIELD];
    logic [7:0]        alm [NFIELD];
    logic [NFIELD-1:0] ok;

    assign cur[0] = regs_i.sec;
    assign cur[1] = regs_i.min;
    assign cur[2] = regs_i.hour;
    assign alm[0] = alarm_sec;
    assign alm[1] = alarm_min;
    assign alm[2] = alarm_hour;

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        assign ok[i] = (alm[i][7:6] == 2'b11) || (alm[i] == cur[i]);
    end

    assign hit_o = &ok;

endmodule

// File: rtl/rtc_cal_engine.sv
module rtc_cal_engine
    import rtc_cal_pkg::*;
#(
    parameter int          UIP_CYCLES   = 8,
    parameter int          BASE_CENTURY = 20,
    parameter logic [2:0]  OSC_RUN_CODE = 3'b010
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic [2:0] osc_sel,
    input  logic       set_hold,
    input  logic       fmt_binary,
    input  logic       fmt_24h,
    input  logic       alarm_en,
    input  logic       upd_irq_en,
    input  logic [7:0] alarm_sec,
    input  logic [7:0] alarm_min,
    input  logic [7:0] alarm_hour,
    input  logic       load_req,
    input  logic [7:0] load_sec,
    input  logic [7:0] load_min,
    input  logic [7:0] load_hour,
    input  logic [7:0] load_wday,
    input  logic [7:0] load_mday,
    input  logic [7:0] load_mon,
    input  logic [7:0] load_year,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       uip_o,
    output logic       uf_pulse_o,
    output logic       af_pulse_o,
    output logic       irq_pulse_o
);

    cal_regs_t load_regs;
    cal_regs_t cur_regs;
    cal_regs_t vis_q;
    cal_time_t load_time;
    cal_time_t cur_time;
    logic      osc_ok;
    logic      adv;
    logic      busy;
    logic      uip;
    logic      finish;
    logic      hit;
    logic      load_d_q;
    logic      uf_q;
    logic      af_q;
    logic      irq_q;

    assign load_regs = '{year: load_year, mon: load_mon, mday: load_mday, wday: load_wday,
                         hour: load_hour, min: load_min, sec: load_sec};

    assign osc_ok = (osc_sel == OSC_RUN_CODE);
    assign adv    = tick_1hz && osc_ok && !busy && !load_req;

    rtc_cal_codec u_codec (
        .fmt_binary  (fmt_binary),
        .fmt_24h     (fmt_24h),
        .time_i      (cur_time),
        .load_regs_i (load_regs),
        .regs_o      (cur_regs),
        .time_o      (load_time)
    );

    rtc_cal_counter #(
        .BASE_CENTURY (BASE_CENTURY)
    ) u_counter (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_req),
        .load_time_i (load_time),
        .adv_i       (adv),
        .time_o      (cur_time)
    );

    rtc_update_seq #(
        .UIP_CYCLES (UIP_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (adv),
        .cancel_i   (load_req),
        .set_hold_i (set_hold),
        .busy_o     (busy),
        .uip_o      (uip),
        .finish_o   (finish)
    );

    rtc_alarm_match u_alarm (
        .regs_i     (cur_regs),
        .alarm_sec  (alarm_sec),
        .alarm_min  (alarm_min),
        .alarm_hour (alarm_hour),
        .hit_o      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q    <= CAL_REGS_RESET;
            load_d_q <= 1'b0;
            uf_q     <= 1'b0;
            af_q     <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            load_d_q <= load_req;
            uf_q     <= finish;
            af_q     <= finish && alarm_en && hit;
            irq_q    <= finish && (upd_irq_en || (alarm_en && hit));
            if ((finish && uip) || load_d_q) begin
                vis_q <= cur_regs;
            end
        end
    end

    assign sec_o       = vis_q.sec;
    assign min_o       = vis_q.min;
    assign hour_o      = vis_q.hour;
    assign wday_o      = vis_q.wday;
    assign mday_o      = vis_q.mday;
    assign mon_o       = vis_q.mon;
    assign year_o      = vis_q.year;
    assign uip_o       = uip;
    assign uf_pulse_o  = uf_q;
    assign af_pulse_o  = af_q;
    assign irq_pulse_o = irq_q;

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker
    import rtc_cal_pkg::*;
#(
    parameter logic [2:0] RUN_CODE = 3'b010
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] osc_sel,
    input logic       set_hold,
    input logic       alarm_en,
    input logic       upd_irq_en,
    input logic       load_req,
    input logic [7:0] sec_o,
    input logic       uip_o,
    input logic       uf_pulse_o,
    input logic       af_pulse_o,
    input logic       irq_pulse_o,
    input cal_time_t  cur_time
);

    // R1: with a stopped oscillator an idle progress flag cannot rise
    p_no_start_stopped_r1: assert property (@(posedge clk) disable iff (rst)
        (osc_sel != RUN_CODE && !uip_o) |=> !uip_o);

    // R2: internal time stays inside its calendar ranges
    p_time_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        cur_time.sec < 6'd60 && cur_time.min < 6'd60 && cur_time.hour < 5'd24 &&
        cur_time.wday >= 3'd1 && cur_time.mon >= 4'd1 && cur_time.mon <= 4'd12 &&
        cur_time.mday >= 5'd1 && cur_time.year < 7'd100);

    // R6: visible seconds change only at the end of a progress window or after a load
    p_regs_move_on_update_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sec_o) |-> ($past(uip_o) || $past(load_req, 2)));

    // R7: hold mode keeps the progress flag low
    p_uip_low_in_set_r7: assert property (@(posedge clk) disable iff (rst)
        set_hold |=> !uip_o);

    // R8: an alarm pulse needs the alarm enable
    p_af_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        af_pulse_o |-> $past(alarm_en));

    // R9: an interrupt request comes with an update end and has a cause
    p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
        irq_pulse_o |-> (uf_pulse_o && (af_pulse_o || $past(upd_irq_en))));

endmodule

bind rtc_cal_engine rtc_cal_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .osc_sel     (osc_sel),
    .set_hold    (set_hold),
    .alarm_en    (alarm_en),
    .upd_irq_en  (upd_irq_en),
    .load_req    (load_req),
    .sec_o       (sec_o),
    .uip_o       (uip_o),
    .uf_pulse_o  (uf_pulse_o),
    .af_pulse_o  (af_pulse_o),
    .irq_pulse_o (irq_pulse_o),
    .cur_time    (cur_time)
);

// File: tb/tb_rtc_cal_engine.sv
module tb_rtc_cal_engine;

    localparam int CLK_PERIOD = 10;
    localparam int UIP        = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [2:0] osc_sel = 3'b010;
    logic       set_hold = 1'b0;
    logic       fmt_binary = 1'b0;
    logic       fmt_24h = 1'b1;
    logic       alarm_en = 1'b0;
    logic       upd_irq_en = 1'b0;
    logic [7:0] alarm_sec = 8'hFF;
    logic [7:0] alarm_min = 8'hFF;
    logic [7:0] alarm_hour = 8'hFF;
    logic       load_req = 1'b0;
    logic [7:0] load_sec = 8'h00;
    logic [7:0] load_min = 8'h00;
    logic [7:0] load_hour = 8'h00;
    logic [7:0] load_wday = 8'h01;
    logic [7:0] load_mday = 8'h01;
    logic [7:0] load_mon = 8'h01;
    logic [7:0] load_year = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
    logic       uip_o, uf_pulse_o, af_pulse_o, irq_pulse_o;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    typedef struct {
        int         at;
        int         fld;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb[$];

    rtc_cal_engine #(.UIP_CYCLES(UIP)) dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .osc_sel(osc_sel), .set_hold(set_hold),
        .fmt_binary(fmt_binary), .fmt_24h(fmt_24h), .alarm_en(alarm_en), .upd_irq_en(upd_irq_en),
        .alarm_sec(alarm_sec), .alarm_min(alarm_min), .alarm_hour(alarm_hour),
        .load_req(load_req), .load_sec(load_sec), .load_min(load_min), .load_hour(load_hour),
        .load_wday(load_wday), .load_mday(load_mday), .load_mon(load_mon), .load_year(load_year),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o),
        .mon_o(mon_o), .year_o(year_o), .uip_o(uip_o), .uf_pulse_o(uf_pulse_o),
        .af_pulse_o(af_pulse_o), .irq_pulse_o(irq_pulse_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] observe(int f);
        case (f)
            0: return sec_o;
            1: return min_o;
            2: return hour_o;
            3: return wday_o;
            4: return mday_o;
            5: return mon_o;
            6: return year_o;
            7: return {7'd0, uip_o};
            8: return {7'd0, uf_pulse_o};
            9: return {7'd0, af_pulse_o};
            default: return {7'd0, irq_pulse_o};
        endcase
    endfunction

    function automatic string fname(int f);
        case (f)
            0: return "sec";   1: return "min";  2: return "hour"; 3: return "wday";
            4: return "mday";  5: return "mon";  6: return "year"; 7: return "uip";
            8: return "uf";    9: return "af";   default: return "irq";
        endcase
    endfunction

    // monitor: pops the expected items due in this cycle and compares
    always @(negedge clk) begin
        item_t it;
        logic [7:0] got;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            it  = sb.pop_front();
            got = observe(it.fld);
            n_checks++;
            if (got !== it.exp) begin
                n_errors++;
                $display("FAIL %s %s: got %02h expected %02h (cycle %0d)",
                         it.req, fname(it.fld), got, it.exp, cyc);
            end
        end
    end

    // driver side: queue an expectation for the next falling edge
    task automatic expect_f(int f, logic [7:0] v, string r);
        item_t it;
        it.at  = cyc + 1;
        it.fld = f;
        it.exp = v;
        it.req = r;
        sb.push_back(it);
    endtask

    task automatic expect_regs(logic [55:0] e, string r);
        for (int i = 0; i < 7; i++) expect_f(i, e[55 - 8*i -: 8], r);
    endtask

    task automatic load_time(logic [55:0] v);
        {load_sec, load_min, load_hour, load_wday, load_mday, load_mon, load_year} = v;
        load_req = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
    endtask

    task automatic pulse_tick();
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic load_and_check(logic [55:0] v, string r);
        load_time(v);
        expect_regs(v, r);
        repeat (2) @(negedge clk);
    endtask

    // fl = {uf, af, irq}
    task automatic do_update(logic [55:0] e, logic uip_e, logic [2:0] fl, string r);
        pulse_tick();
        expect_f(7, {7'd0, uip_e}, r);
        repeat (UIP - 1) @(negedge clk);
        expect_regs(e, r);
        expect_f(7, 8'h00, r);
        expect_f(8, {7'd0, fl[2]}, r);
        expect_f(9, {7'd0, fl[1]}, r);
        expect_f(10, {7'd0, fl[0]}, r);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        expect_regs({8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00}, "R11");
        for (int f = 7; f <= 10; f++) expect_f(f, 8'h00, "R11");
        repeat (2) @(negedge clk);

        // R10 load, R2 full rollover into a new year
        load_and_check({8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99}, "R10");
        pulse_tick();
        expect_f(7, 8'h01, "R6");
        expect_f(0, 8'h59, "R6");
        repeat (UIP - 2) @(negedge clk);
        expect_f(0, 8'h59, "R6");
        expect_f(7, 8'h01, "R6");
        @(negedge clk);
        expect_regs({8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00}, "R2");
        expect_f(7, 8'h00, "R6");
        expect_f(8, 8'h01, "R9");
        repeat (2) @(negedge clk);

        // R3 month lengths and leap years
        load_time({8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h00});
        repeat (2) @(negedge clk);
        do_update({8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h00}, 1'b1, 3'b100, "R3");
        load_time({8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h01});
        repeat (2) @(negedge clk);
        do_update({8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h01}, 1'b1, 3'b100, "R3");
        load_time({8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h24});
        repeat (2) @(negedge clk);
        do_update({8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h24}, 1'b1, 3'b100, "R3");

        // R5 12-hour BCD: 11 AM to noon, 11 PM to midnight
        fmt_24h = 1'b0;
        load_time({8'h59, 8'h59, 8'h11, 8'h01, 8'h15, 8'h06, 8'h24});
        repeat (2) @(negedge clk);
        do_update({8'h00, 8'h00, 8'h80, 8'h01, 8'h15, 8'h06, 8'h24}, 1'b1, 3'b100, "R5");
        load_time({8'h59, 8'h59, 8'h91, 8'h01, 8'h15, 8'h06, 8'h24});
        repeat (2) @(negedge clk);
        do_update({8'h00, 8'h00, 8'h00, 8'h02, 8'h16, 8'h06, 8'h24}, 1'b1, 3'b100, "R5");

        // R4 binary 24-hour
        fmt_24h = 1'b1;
        fmt_binary = 1'b1;
        load_and_check({8'h2A, 8'h05, 8'h0D, 8'h02, 8'h1C, 8'h02, 8'h10}, "R4");
        do_update({8'h2B, 8'h05, 8'h0D, 8'h02, 8'h1C, 8'h02, 8'h10}, 1'b1, 3'b100, "R4");
        load_time({8'h3B, 8'h3B, 8'h0D, 8'h02, 8'h1C, 8'h02, 8'h10});
        repeat (2) @(negedge clk);
        do_update({8'h00, 8'h00, 8'h0E, 8'h02, 8'h1C, 8'h02, 8'h10}, 1'b1, 3'b100, "R4");
        fmt_binary = 1'b0;

        // R1 stopped oscillator
        load_time({8'h30, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24});
        repeat (2) @(negedge clk);
        osc_sel = 3'b000;
        do_update({8'h30, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b0, 3'b000, "R1");
        osc_sel = 3'b110;
        do_update({8'h30, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b0, 3'b000, "R1");
        osc_sel = 3'b010;

        // R7 hold mode: no progress flag, no refresh, time still counts
        set_hold = 1'b1;
        do_update({8'h30, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b0, 3'b100, "R7");
        set_hold = 1'b0;
        do_update({8'h32, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b1, 3'b100, "R7");

        // R8 alarm matching with wildcards
        alarm_en   = 1'b1;
        alarm_sec  = 8'h33;
        alarm_min  = 8'hC0;
        alarm_hour = 8'hFF;
        do_update({8'h33, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b1, 3'b111, "R8");
        do_update({8'h34, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b1, 3'b100, "R8");
        alarm_sec = 8'h35;
        alarm_min = 8'h21;
        do_update({8'h35, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b1, 3'b100, "R8");
        alarm_sec  = 8'hC5;
        alarm_min  = 8'h20;
        alarm_hour = 8'h10;
        do_update({8'h36, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b1, 3'b111, "R8");
        alarm_en = 1'b0;
        do_update({8'h37, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b1, 3'b100, "R8");

        // R9 update-ended interrupt enable
        upd_irq_en = 1'b1;
        do_update({8'h38, 8'h20, 8'h10, 8'h02, 8'h10, 8'h03, 8'h24}, 1'b1, 3'b101, "R9");

        // R10 load abandons an open window
        pulse_tick();
        expect_f(7, 8'h01, "R10");
        @(negedge clk);
        load_time({8'h00, 8'h45, 8'h08, 8'h03, 8'h11, 8'h03, 8'h24});
        expect_f(7, 8'h00, "R10");
        expect_regs({8'h00, 8'h45, 8'h08, 8'h03, 8'h11, 8'h03, 8'h24}, "R10");
        repeat (5) @(negedge clk);
        expect_f(8, 8'h00, "R10");
        expect_f(10, 8'h00, "R10");
        @(negedge clk);
        expect_f(8, 8'h00, "R10");
        expect_f(0, 8'h00, "R10");
        repeat (4) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule